// File: doc/BRIEF.md
# Microcontroller Register Bus Bridge

This block is a slave bridge. It connects an external asynchronous microcontroller bus to an internal register file. A two-bit mode input picks the strobe style:

- Separate read and write strobes.
- A single data strobe with a read/write direction line.

A width input selects an 8-bit or a 16-bit data bus. In separate-strobe mode, the bridge watches the address latch enable. Once that line toggles, the address is taken from the data lines while the enable is high, which suits a multiplexed bus. While the enable stays at a constant level, the dedicated address pins are used.

All bus inputs pass through two-flop synchronisers into the system clock. The bridge decodes the byte-high/low enable together with address bit 0 to find the transfer size. It then steers the bytes between the bus lanes and the internal even/odd register bytes. The lane order depends on the strobe style.

On the internal side, the bridge issues single-cycle read and write strobes. Each strobe comes with a word address and two byte enables. The register side has no back-pressure: the register file must take each write pulse in the cycle it is high. It must also present read data combinationally in the cycle the read pulse is high.

Towards the bus, a ready line drops while an access is being served. The data pins are modelled as an input vector, an output vector and an output-enable. The pad-level three-state buffer sits outside this block.

Top module: `mpu_reg_bridge`

## Requirements
- R1: `cfg_mode` = 01 selects data-strobe style: `bus_rd_n` is the data strobe and `bus_wr_n` is read/write (1 = read, 0 = write). Any other code selects separate-strobe style: `bus_rd_n` low reads and `bus_wr_n` low writes. In both styles an access needs `bus_cs_n` low.
- R2: In separate-strobe style, the first toggle of `bus_ale` switches the bridge to multiplexed addressing, and it stays there. After that, the address is captured from `bus_d_in` while `bus_ale` is high. While `bus_ale` has never toggled, the address comes from `bus_addr`.
- R3: In 16-bit mode, {`bus_bhe_n`, A0} decodes as follows. 00 is a word access, with `reg_be` = 11. 01 is an odd byte, with `reg_be` = 10. 10 is an even byte, with `reg_be` = 01. 11 performs no transfer, and neither `reg_wr` nor `reg_rd` pulses.
- R4: In separate-strobe 16-bit mode, the even register byte (`reg_wdata`/`reg_rdata` bits 7:0) uses bus lane D7:0, and the odd byte (bits 15:8) uses lane D15:8.
- R5: In data-strobe 16-bit mode, the lanes are swapped. The even byte uses D15:8 and the odd byte uses D7:0, and a word uses both lanes.
- R6: In 8-bit mode (`cfg_wide` = 0), every access is a byte access selected by A0 alone, and `bus_bhe_n` is ignored. Write data is taken from D7:0. Read data appears on D7:0, with D15:8 driven as zero.
- R7: A write produces exactly one `reg_wr` pulse. The pulse is high in the third cycle after the strobe is released, and it carries the data that was present while the strobe was active.
- R8: `bus_ready` is high out of reset. It goes low in the third cycle after an access starts. For a read it goes high again in the fifth cycle after the access starts. For a write it goes high again in the fourth cycle after the strobe is released.
- R9: A read raises `reg_rd` for one cycle, in the fourth cycle after the access starts, with `reg_addr` stable. The steered read data is on `bus_d_out` from the fifth cycle.
- R10: `bus_d_oe` is high only while `bus_cs_n` is low and a read strobe is active. In separate-strobe style that means `bus_rd_n` is low. In data-strobe style it means `bus_rd_n` is low with `bus_wr_n` high.
- R11: Byte and word accesses may follow one another in any order. Each access acts only on the bytes it selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cfg_mode | input | 2 | Strobe style, 01 = data strobe + read/write line |
| cfg_wide | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_rd_n | input | 1 | Read strobe, or data strobe in data-strobe style |
| bus_wr_n | input | 1 | Write strobe, or read/write direction in data-strobe style |
| bus_ale | input | 1 | Address latch enable |
| bus_bhe_n | input | 1 | Byte-high/low enable, active low |
| bus_addr | input | ADDR_W | Demultiplexed address pins |
| bus_d_in | input | 16 | Data lines as seen at the pad |
| bus_d_out | output | 16 | Read data towards the pad |
| bus_d_oe | output | 1 | Pad output enable |
| bus_ready | output | 1 | High when no access is pending |
| reg_addr | output | ADDR_W-1 | Register word address |
| reg_wr | output | 1 | Single-cycle write strobe |
| reg_rd | output | 1 | Single-cycle read strobe |
| reg_be | output | 2 | Byte enables, bit 0 = even byte, bit 1 = odd byte |
| reg_wdata | output | 16 | Write data, bits 7:0 = even byte |
| reg_rdata | input | 16 | Read data, bits 7:0 = even byte |

## Verification
Every result is counted in clock edges from the first edge that sees a changed bus input. Two synchroniser edges come first, and an access start is registered on the third edge. So `bus_ready` falls after edge 3, `reg_rd` is high after edge 4, and read data with ready high follows edge 5. On strobe release, `reg_wr` is high after edge 3 and ready returns after edge 4. The bench drives and samples on falling clock edges and counts that many falling edges before each sample. It also checks ready one edge early to pin the exact cycle.

// File: rtl/mpu_bridge_pkg.sv
package mpu_bridge_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam logic [1:0] MODE_DSTROBE = 2'b01;

  typedef enum logic [2:0] {
    ACC_IDLE,
    ACC_RD_ISSUE,
    ACC_RD_TAKE,
    ACC_WAIT_END,
    ACC_WR_DONE
  } acc_state_t;
endpackage

// File: rtl/mpu_sync.sv
module mpu_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  input  logic [W-1:0] rst_val,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= rst_val;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mpu_lane_map.sv
module mpu_lane_map
  import mpu_bridge_pkg::*;
(
  input  logic              wide,
  input  logic              dstrobe,
  input  logic              bhe_n,
  input  logic              a0,
  input  logic [WORD_W-1:0] bus_wdata,
  input  logic [WORD_W-1:0] reg_rword,
  output logic [1:0]        be,
  output logic [WORD_W-1:0] wword,
  output logic [WORD_W-1:0] bus_rword
);
  logic              swap;
  logic [1:0]        lane_en;
  logic [WORD_W-1:0] rsrc;

  always_comb begin
    swap = wide & dstrobe;
    // even enable tracks A0 low; odd enable tracks bhe_n low (16-bit) or A0 high (8-bit)
    be   = wide ? {~bhe_n, ~a0} : {a0, ~a0};

    if (!wide)
      wword = {bus_wdata[BYTE_W-1:0], bus_wdata[BYTE_W-1:0]};
    else if (swap)
      wword = {bus_wdata[BYTE_W-1:0], bus_wdata[WORD_W-1:BYTE_W]};
    else
      wword = bus_wdata;

    if (!wide) begin
      lane_en = 2'b01;
      rsrc    = {{BYTE_W{1'b0}}, a0 ? reg_rword[WORD_W-1:BYTE_W] : reg_rword[BYTE_W-1:0]};
    end else if (swap) begin
      lane_en = {be[0], be[1]};
      rsrc    = {reg_rword[BYTE_W-1:0], reg_rword[WORD_W-1:BYTE_W]};
    end else begin
      lane_en = be;
      rsrc    = reg_rword;
    end

    bus_rword = rsrc & {{BYTE_W{lane_en[1]}}, {BYTE_W{lane_en[0]}}};
  end
endmodule

// File: rtl/mpu_access_ctl.sv
module mpu_access_ctl
  import mpu_bridge_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act,
  input  logic              is_wr,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              bhe_n_in,
  input  logic [WORD_W-1:0] din,
  input  logic [1:0]        lane_be,
  input  logic [WORD_W-1:0] lane_wword,
  input  logic [WORD_W-1:0] lane_rword,
  output logic              cap_a0,
  output logic              cap_bhe_n,
  output logic [WORD_W-1:0] wr_hold,
  output logic [ADDR_W-2:0] reg_addr,
  output logic              reg_wr,
  output logic              reg_rd,
  output logic [1:0]        reg_be,
  output logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] rd_hold,
  output logic              ready
);
  acc_state_t        state;
  logic              cap_wr;
  logic [ADDR_W-1:0] cap_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ACC_IDLE;
      cap_wr    <= 1'b0;
      cap_addr  <= '0;
      cap_bhe_n <= 1'b1;
      wr_hold   <= '0;
      rd_hold   <= '0;
      reg_wr    <= 1'b0;
      reg_rd    <= 1'b0;
      reg_be    <= 2'b00;
      reg_wdata <= '0;
      ready     <= 1'b1;
    end else begin
      reg_wr <= 1'b0;
      reg_rd <= 1'b0;
      if (act) wr_hold <= din;
      unique case (state)
        ACC_IDLE: if (act) begin
          cap_wr    <= is_wr;
          cap_addr  <= addr_in;
          cap_bhe_n <= bhe_n_in;
          ready     <= 1'b0;
          state     <= is_wr ? ACC_WAIT_END : ACC_RD_ISSUE;
        end
        ACC_RD_ISSUE: begin
          reg_rd <= |lane_be;
          reg_be <= lane_be;
          state  <= ACC_RD_TAKE;
        end
        ACC_RD_TAKE: begin
          rd_hold <= lane_rword;
          ready   <= 1'b1;
          state   <= ACC_WAIT_END;
        end
        ACC_WAIT_END: if (!act) begin
          if (cap_wr) begin
            reg_wr    <= |lane_be;
            reg_be    <= lane_be;
            reg_wdata <= lane_wword;
            state     <= ACC_WR_DONE;
          end else begin
            state <= ACC_IDLE;
          end
        end
        ACC_WR_DONE: begin
          ready <= 1'b1;
          state <= ACC_IDLE;
        end
        default: state <= ACC_IDLE;
      endcase
    end
  end

  assign cap_a0   = cap_addr[0];
  assign reg_addr = cap_addr[ADDR_W-1:1];

  assert_wr_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);
  assert_rd_once_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> (!reg_rd && ready));
  assert_rd_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |-> $stable(reg_addr));
  assert_no_xfer_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr || reg_rd) |-> (reg_be != 2'b00));
  assert_wr_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> !ready);
  assert_wr_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> ready);
  assert_start_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ACC_IDLE && act) |=> !ready);
endmodule

// File: rtl/mpu_reg_bridge.sv
module mpu_reg_bridge
  import mpu_bridge_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_wide,
  input  logic              bus_cs_n,
  input  logic              bus_rd_n,
  input  logic              bus_wr_n,
  input  logic              bus_ale,
  input  logic              bus_bhe_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_d_in,
  output logic [WORD_W-1:0] bus_d_out,
  output logic              bus_d_oe,
  output logic              bus_ready,
  output logic [ADDR_W-2:0] reg_addr,
  output logic              reg_wr,
  output logic              reg_rd,
  output logic [1:0]        reg_be,
  output logic [WORD_W-1:0] reg_wdata,
  input  logic [WORD_W-1:0] reg_rdata
);
  localparam int PACK_W = 1 + ADDR_W + WORD_W;

  logic [3:0]        ctl_s;
  logic [PACK_W-1:0] pk_s;
  logic              ale_s, cs_s, rd_s, wr_s, bhe_s;
  logic [ADDR_W-1:0] addr_s, addr_lat, acc_addr;
  logic [WORD_W-1:0] din_s;
  logic              dstrobe, ale_d, mux_seen, act_s;

  mpu_sync #(.W(4), .STAGES(SYNC_STAGES)) u_ctl_sync (
    .clk, .rst_n,
    .d      ({bus_ale, bus_cs_n, bus_rd_n, bus_wr_n}),
    .rst_val(4'b0111),
    .q      (ctl_s)
  );

  mpu_sync #(.W(PACK_W), .STAGES(SYNC_STAGES)) u_dat_sync (
    .clk, .rst_n,
    .d      ({bus_bhe_n, bus_addr, bus_d_in}),
    .rst_val({PACK_W{1'b1}}),
    .q      (pk_s)
  );

  assign {ale_s, cs_s, rd_s, wr_s} = ctl_s;
  assign bhe_s   = pk_s[PACK_W-1];
  assign addr_s  = pk_s[WORD_W +: ADDR_W];
  assign din_s   = pk_s[WORD_W-1:0];
  assign dstrobe = (cfg_mode == MODE_DSTROBE);

  // multiplexed-bus detection and address capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_d    <= 1'b0;
      mux_seen <= 1'b0;
      addr_lat <= '0;
    end else begin
      ale_d <= ale_s;
      if (!dstrobe && (ale_s != ale_d)) mux_seen <= 1'b1;
      if (ale_s) addr_lat <= din_s[ADDR_W-1:0];
    end
  end

  assign acc_addr = (!dstrobe && mux_seen) ? addr_lat : addr_s;
  assign act_s    = dstrobe ? (~cs_s & ~rd_s) : (~cs_s & (~rd_s | ~wr_s));

  logic              cap_a0, cap_bhe_n;
  logic [WORD_W-1:0] wr_hold, rd_hold, lane_wword, lane_rword;
  logic [1:0]        lane_be;

  mpu_lane_map u_lane (
    .wide     (cfg_wide),
    .dstrobe  (dstrobe),
    .bhe_n    (cap_bhe_n),
    .a0       (cap_a0),
    .bus_wdata(wr_hold),
    .reg_rword(reg_rdata),
    .be       (lane_be),
    .wword    (lane_wword),
    .bus_rword(lane_rword)
  );

  mpu_access_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk, .rst_n,
    .act       (act_s),
    .is_wr     (~wr_s),
    .addr_in   (acc_addr),
    .bhe_n_in  (bhe_s),
    .din       (din_s),
    .lane_be   (lane_be),
    .lane_wword(lane_wword),
    .lane_rword(lane_rword),
    .cap_a0    (cap_a0),
    .cap_bhe_n (cap_bhe_n),
    .wr_hold   (wr_hold),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_be    (reg_be),
    .reg_wdata (reg_wdata),
    .rd_hold   (rd_hold),
    .ready     (bus_ready)
  );

  // pad enable follows the raw strobes so the bus is released without delay
  assign bus_d_oe  = ~bus_cs_n & ~bus_rd_n & (dstrobe ? bus_wr_n : 1'b1);
  assign bus_d_out = rd_hold;

  assert_mux_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mux_seen && !dstrobe && !ale_s && !ale_d) |=> $stable(addr_lat));
  assert_ready_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd || reg_wr) |-> !bus_ready);
endmodule

// File: tb/mpu_reg_bridge_test.sv
module mpu_reg_bridge_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_mode = 2'b00;
  logic        cfg_wide = 1'b1;
  logic        bus_cs_n = 1'b1, bus_rd_n = 1'b1, bus_wr_n = 1'b1;
  logic        bus_ale = 1'b0, bus_bhe_n = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic [15:0] bus_d_in = '0;
  logic [15:0] bus_d_out, reg_wdata, reg_rdata;
  logic        bus_d_oe, bus_ready, reg_wr, reg_rd;
  logic [6:0]  reg_addr;
  logic [1:0]  reg_be;

  int total = 0, bad = 0, wr_cnt = 0;
  logic [6:0]  last_waddr;
  logic [15:0] last_wdata, rd_val;
  logic [1:0]  last_wbe;
  logic        saw_rd, saw_wr, oe_val;
  logic [15:0] mem [0:127];

  always #(CLK_PERIOD/2) clk = ~clk;

  mpu_reg_bridge uut (
    .clk, .rst_n, .cfg_mode, .cfg_wide, .bus_cs_n, .bus_rd_n, .bus_wr_n,
    .bus_ale, .bus_bhe_n, .bus_addr, .bus_d_in, .bus_d_out, .bus_d_oe,
    .bus_ready, .reg_addr, .reg_wr, .reg_rd, .reg_be, .reg_wdata, .reg_rdata
  );

  function automatic logic [15:0] init_val(input logic [6:0] w);
    return {~{1'b0, w}, {1'b0, w} + 8'h11};
  endfunction

  assign reg_rdata = mem[reg_addr];

  always @(posedge clk) begin
    if (reg_wr) begin
      wr_cnt     <= wr_cnt + 1;
      last_waddr <= reg_addr;
      last_wdata <= reg_wdata;
      last_wbe   <= reg_be;
      if (reg_be[0]) mem[reg_addr][7:0]  <= reg_wdata[7:0];
      if (reg_be[1]) mem[reg_addr][15:8] <= reg_wdata[15:8];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one bus access, aligned to falling edges; checks ready timing (R8, R7)
  task automatic access(input bit wr, input logic [7:0] a, input logic bhe,
                        input logic [15:0] wd, input bit mux);
    if (mux) begin
      bus_ale = 1'b1; bus_d_in = {8'h00, a}; bus_addr = 8'h00;
      repeat (4) @(negedge clk);
      bus_ale = 1'b0;
      repeat (2) @(negedge clk);
    end else begin
      bus_addr = a;
    end
    bus_bhe_n = bhe;
    bus_d_in  = wr ? wd : 16'h0000;
    bus_cs_n  = 1'b0;
    if (cfg_mode == 2'b01) begin
      bus_wr_n = ~wr; bus_rd_n = 1'b0;
    end else if (wr) bus_wr_n = 1'b0;
    else bus_rd_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8 ready still high before sync", bus_ready, 1);
    @(negedge clk);
    chk("R8 ready low at access start", bus_ready, 0);
    if (!wr) begin
      @(negedge clk); saw_rd = reg_rd;
      @(negedge clk);
      chk("R8 ready high after read data", bus_ready, 1);
      rd_val = bus_d_out; oe_val = bus_d_oe;
    end else begin
      repeat (2) @(negedge clk);
    end
    bus_cs_n = 1'b1; bus_rd_n = 1'b1; bus_wr_n = 1'b1;
    if (wr) begin
      repeat (2) @(negedge clk);
      chk("R8 ready low until commit", bus_ready, 0);
      @(negedge clk); saw_wr = reg_wr;
      @(negedge clk);
      chk("R8 ready high after write", bus_ready, 1);
      chk("R7 write pulse single", reg_wr, 0);
    end else begin
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk("R8 reset ready", bus_ready, 1);
    chk("R7 reset reg_wr", reg_wr, 0);
    chk("R9 reset reg_rd", reg_rd, 0);
    chk("R10 reset oe", bus_d_oe, 0);
  endtask

  task automatic t_sep_write();
    int n;
    cfg_mode = 2'b00; cfg_wide = 1'b1;
    n = wr_cnt;
    access(1, 8'h10, 1'b0, 16'hBEEF, 0);
    chk("R7 one write pulse", wr_cnt, n + 1);
    chk("R1 separate strobe write seen", saw_wr, 1);
    chk("R3 word be", last_wbe, 2'b11);
    chk("R4 word data", last_wdata, 16'hBEEF);
    chk("R2 demux address pins", last_waddr, 7'h08);
    access(1, 8'h13, 1'b0, 16'hC311, 0);
    chk("R3 odd byte be", last_wbe, 2'b10);
    chk("R4 odd byte from D15:8", last_wdata[15:8], 8'hC3);
    access(1, 8'h14, 1'b1, 16'h995D, 0);
    chk("R3 even byte be", last_wbe, 2'b01);
    chk("R4 even byte from D7:0", last_wdata[7:0], 8'h5D);
    n = wr_cnt;
    access(1, 8'h17, 1'b1, 16'h7777, 0);
    chk("R3 no transfer write", wr_cnt, n);
    chk("R3 no transfer pulse", saw_wr, 0);
  endtask

  task automatic t_sep_read();
    logic [15:0] e;
    cfg_mode = 2'b00; cfg_wide = 1'b1;
    access(0, 8'h40, 1'b0, 16'h0, 0);
    chk("R9 read pulse", saw_rd, 1);
    chk("R10 oe during read", oe_val, 1);
    chk("R4 word read", rd_val, init_val(7'h20));
    e = init_val(7'h21);
    access(0, 8'h43, 1'b0, 16'h0, 0);
    chk("R4 odd byte read on D15:8", rd_val, {e[15:8], 8'h00});
    access(0, 8'h45, 1'b1, 16'h0, 0);
    chk("R3 no transfer read", saw_rd, 0);
  endtask

  task automatic t_oe();
    @(negedge clk);
    bus_cs_n = 1'b1; bus_rd_n = 1'b0;
    #1 chk("R10 no oe without select", bus_d_oe, 0);
    cfg_mode = 2'b01; bus_wr_n = 1'b1;
    #1 chk("R10 no oe data strobe without select", bus_d_oe, 0);
    bus_rd_n = 1'b1; cfg_mode = 2'b00;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_dstrobe();
    logic [15:0] e;
    cfg_mode = 2'b01; cfg_wide = 1'b1;
    access(1, 8'h20, 1'b0, 16'hBEEF, 0);
    chk("R1 data strobe write seen", saw_wr, 1);
    chk("R5 word swapped", last_wdata, 16'hEFBE);
    access(1, 8'h21, 1'b0, 16'h005A, 0);
    chk("R5 odd byte be", last_wbe, 2'b10);
    chk("R5 odd byte from D7:0", last_wdata[15:8], 8'h5A);
    e = init_val(7'h22);
    access(0, 8'h44, 1'b1, 16'h0, 0);
    chk("R5 even byte read on D15:8", rd_val, {e[7:0], 8'h00});
    e = init_val(7'h23);
    access(0, 8'h47, 1'b0, 16'h0, 0);
    chk("R5 odd byte read on D7:0", rd_val, {8'h00, e[15:8]});
  endtask

  task automatic t_narrow();
    logic [15:0] e;
    cfg_mode = 2'b00; cfg_wide = 1'b0;
    access(1, 8'h31, 1'b1, 16'hFF77, 0);
    chk("R6 8-bit odd write be", last_wbe, 2'b10);
    chk("R6 8-bit data from D7:0", last_wdata[15:8], 8'h77);
    e = init_val(7'h27);
    access(0, 8'h4F, 1'b1, 16'h0, 0);
    chk("R6 8-bit odd read", rd_val, {8'h00, e[15:8]});
    e = init_val(7'h26);
    access(0, 8'h4C, 1'b0, 16'h0, 0);
    chk("R6 8-bit even read", rd_val, {8'h00, e[7:0]});
    cfg_wide = 1'b1;
  endtask

  task automatic t_mixed();
    cfg_mode = 2'b00; cfg_wide = 1'b1;
    access(1, 8'h60, 1'b0, 16'h1234, 0);
    access(1, 8'h61, 1'b0, 16'hAB00, 0);
    access(0, 8'h60, 1'b0, 16'h0, 0);
    chk("R11 word after byte merge", rd_val, 16'hAB34);
    access(0, 8'h60, 1'b1, 16'h0, 0);
    chk("R11 byte after word", rd_val, 16'h0034);
  endtask

  task automatic t_mux();
    cfg_mode = 2'b00; cfg_wide = 1'b1;
    access(1, 8'h52, 1'b0, 16'h4242, 1);
    chk("R2 muxed address latched", last_waddr, 7'h29);
    access(0, 8'h46, 1'b0, 16'h0, 1);
    chk("R2 muxed read", rd_val, init_val(7'h23));
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = init_val(7'(i));
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_sep_write();
    t_sep_read();
    t_oe();
    t_dstrobe();
    t_narrow();
    t_mixed();
    t_mux();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule